// File: doc/BRIEF.md
# Privilege and Stack Pointer Control Unit

This block keeps the processor's supervisor/user state in a status register. One bit of that register, the supervisor flag, decides three things. It picks which of two banked stack pointers answers for architectural register 7. It decides which instruction classes are refused. It sets the upper bit of the 3-bit function code that tags every bus access.

Decode logic presents class flags for the current instruction. The block answers with a registered privilege-violation request one cycle later. At supervisor level, a dedicated user-stack move path reaches the user stack pointer. Exception entry saves the status register for stacking and forces supervisor level. Exception return restores the saved copy, so it can drop back to user level.

Top module: `priv_sp_ctrl`

## Requirements
- R1: After a synchronous reset, `sr_out` is 16'h2000 (supervisor flag set, every other bit clear). `sr_saved` is 0, `sp_out` is 0, and `priv_trap` is 0.
- R2: The supervisor flag is bit 13 of the status register. `fc_out` is 3'b111 when `bus_cpu` is 1. Otherwise it is 3'b110 for a supervisor program access, 3'b101 for supervisor data, 3'b010 for user program and 3'b001 for user data. `bus_prog` picks program (1) or data (0).
- R3: `sp_out` shows the supervisor stack pointer while the flag is 1 and the user stack pointer while it is 0. A write through `a7_wr_en` updates the bank that `sp_out` selects, and the new value appears after the next rising edge.
- R4: A register-7 write at user level changes only the user stack pointer. The supervisor stack pointer keeps its value, which shows once supervisor level returns.
- R5: A valid stop, low-power-stop or reset instruction at user level raises `priv_trap` for exactly one cycle, after the next edge. At supervisor level these raise no request.
- R6: A valid status-write-class instruction at user level raises `priv_trap`. Status-register writes through `sr_wr_en` are ignored at user level.
- R7: At supervisor level, while a valid user-stack move is presented, `sp_out` shows the user stack pointer and a register-7 write goes to the user stack pointer.
- R8: On `exc_enter`, `sr_saved` takes the old status register and the supervisor flag is set after the same edge. Bus cycles after entry carry a supervisor function code.
- R9: On `exc_return` without `exc_enter`, the status register takes the value of `sr_saved`.
- R10: `exc_enter` takes priority over `exc_return` and over `sr_wr_en` in the same cycle.
- R11: A valid user-stack move at user level raises `priv_trap`, and its register-7 write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Class flags below are valid this cycle |
| ins_stop | input | 1 | Stop instruction |
| ins_lpstop | input | 1 | Low-power stop instruction |
| ins_reset | input | 1 | External-reset instruction |
| ins_sr_write | input | 1 | Instruction that can alter the supervisor flag |
| ins_usp_move | input | 1 | Move to/from user stack pointer |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| sr_wr_en | input | 1 | Status register write enable |
| sr_wr_data | input | 16 | Status register write value |
| a7_wr_en | input | 1 | Register 7 write enable |
| a7_wr_data | input | 32 | Register 7 write value |
| bus_prog | input | 1 | Current access is a program fetch |
| bus_cpu | input | 1 | Current access is a CPU-space cycle |
| sp_out | output | 32 | Active stack pointer value |
| priv_trap | output | 1 | Privilege-violation request |
| fc_out | output | 3 | Function code for the bus access |
| sr_out | output | 16 | Current status register |
| sr_saved | output | 16 | Status register saved at exception entry |

## Verification
A wrong supervisor flag shows at once in the top bit of `fc_out` and in the bank that `sp_out` selects. Within one edge it also shows in whether `priv_trap` fires. A write that lands in the wrong bank stays hidden until the privilege level flips, so the bench loads both banks with distinct values and crosses levels through status writes, exception entry and exception return. Ignored writes are checked by reading the untouched bank back through `sp_out` and `sr_out` afterwards.

// File: rtl/priv_pkg.sv
package priv_pkg;
  localparam int FC_W = 3;
  localparam logic [FC_W-1:0] FC_USR_DATA = 3'b001;
  localparam logic [FC_W-1:0] FC_USR_PROG = 3'b010;
  localparam logic [FC_W-1:0] FC_SUP_DATA = 3'b101;
  localparam logic [FC_W-1:0] FC_SUP_PROG = 3'b110;
  localparam logic [FC_W-1:0] FC_CPU      = 3'b111;

  // instruction class bit positions
  localparam int CLS_STOP   = 0;
  localparam int CLS_LPSTOP = 1;
  localparam int CLS_RESET  = 2;
  localparam int CLS_SRW    = 3;
  localparam int CLS_USP    = 4;
  localparam int NCLS       = 5;

  localparam int BANK_USR = 0;
  localparam int BANK_SUP = 1;
  localparam int NBANK    = 2;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl #(
  parameter int SR_W  = 16,
  parameter int S_POS = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_enter,
  input  logic            exc_return,
  input  logic            wr_en,
  input  logic [SR_W-1:0] wr_data,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] saved_q,
  output logic            s_bit
);
  localparam logic [SR_W-1:0] S_MASK = SR_W'(1) << S_POS;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= S_MASK;
      saved_q <= '0;
    end else if (exc_enter) begin
      saved_q <= sr_q;
      sr_q    <= sr_q | S_MASK;
    end else if (exc_return) begin
      sr_q <= saved_q;
    end else if (wr_en && sr_q[S_POS]) begin
      sr_q <= wr_data;
    end
  end

  assign s_bit = sr_q[S_POS];

  // R8
  enter_sets_s_chk: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> s_bit);

  // R9
  return_restores_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_return && !exc_enter) |=> (sr_q == $past(saved_q)));
endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import priv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_bit,
  input  logic          usp_path,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] sp_out
);
  logic [NBANK-1:0][DW-1:0] bank_q;
  logic [NBANK-1:0]         bank_we;
  logic                     rd_sup;

  // user level: plain register-7 writes only; move path is refused
  // supervisor level: move path steers to the user bank
  always_comb begin
    bank_we           = '0;
    bank_we[BANK_USR] = wr_en && (s_bit ? usp_path : !usp_path);
    bank_we[BANK_SUP] = wr_en && s_bit && !usp_path;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)             bank_q[g] <= '0;
      else if (bank_we[g]) bank_q[g] <= wr_data;
    end
  end

  assign rd_sup = s_bit && !usp_path;
  assign sp_out = rd_sup ? bank_q[BANK_SUP] : bank_q[BANK_USR];

  // R4
  user_keeps_ssp_chk: assert property (@(posedge clk) disable iff (rst)
    !s_bit |=> $stable(bank_q[BANK_SUP]));
endmodule

// File: rtl/priv_check.sv
module priv_check
  import priv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            s_bit,
  input  logic            ins_valid,
  input  logic [NCLS-1:0] ins_cls,
  output logic            trap_q
);
  logic violate;

  assign violate = ins_valid && !s_bit && (|ins_cls);

  always_ff @(posedge clk) begin
    if (rst) trap_q <= 1'b0;
    else     trap_q <= violate;
  end

  // R5
  trap_only_user_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> $past(!s_bit && ins_valid));
endmodule

// File: rtl/fc_gen.sv
module fc_gen
  import priv_pkg::*;
(
  input  logic            s_bit,
  input  logic            prog,
  input  logic            cpu,
  output logic [FC_W-1:0] fc
);
  always_comb begin
    if (cpu)               fc = FC_CPU;
    else if (s_bit &&  prog) fc = FC_SUP_PROG;
    else if (s_bit)          fc = FC_SUP_DATA;
    else if (prog)           fc = FC_USR_PROG;
    else                     fc = FC_USR_DATA;
  end
endmodule

// File: rtl/priv_sp_ctrl.sv
module priv_sp_ctrl
  import priv_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SR_W  = 16,
  parameter int S_POS = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic            ins_stop,
  input  logic            ins_lpstop,
  input  logic            ins_reset,
  input  logic            ins_sr_write,
  input  logic            ins_usp_move,
  input  logic            exc_enter,
  input  logic            exc_return,
  input  logic            sr_wr_en,
  input  logic [SR_W-1:0] sr_wr_data,
  input  logic            a7_wr_en,
  input  logic [DW-1:0]   a7_wr_data,
  input  logic            bus_prog,
  input  logic            bus_cpu,
  output logic [DW-1:0]   sp_out,
  output logic            priv_trap,
  output logic [FC_W-1:0] fc_out,
  output logic [SR_W-1:0] sr_out,
  output logic [SR_W-1:0] sr_saved
);
  logic            s_bit;
  logic [NCLS-1:0] cls;
  logic            usp_path;

  always_comb begin
    cls             = '0;
    cls[CLS_STOP]   = ins_stop;
    cls[CLS_LPSTOP] = ins_lpstop;
    cls[CLS_RESET]  = ins_reset;
    cls[CLS_SRW]    = ins_sr_write;
    cls[CLS_USP]    = ins_usp_move;
  end

  assign usp_path = ins_valid && ins_usp_move;

  sr_ctrl #(.SR_W(SR_W), .S_POS(S_POS)) u_sr (
    .clk(clk), .rst(rst), .exc_enter(exc_enter), .exc_return(exc_return),
    .wr_en(sr_wr_en), .wr_data(sr_wr_data),
    .sr_q(sr_out), .saved_q(sr_saved), .s_bit(s_bit)
  );

  sp_bank #(.DW(DW)) u_sp (
    .clk(clk), .rst(rst), .s_bit(s_bit), .usp_path(usp_path),
    .wr_en(a7_wr_en), .wr_data(a7_wr_data), .sp_out(sp_out)
  );

  priv_check u_chk (
    .clk(clk), .rst(rst), .s_bit(s_bit), .ins_valid(ins_valid),
    .ins_cls(cls), .trap_q(priv_trap)
  );

  fc_gen u_fc (
    .s_bit(s_bit), .prog(bus_prog), .cpu(bus_cpu), .fc(fc_out)
  );

  // R8
  enter_fc_sup_chk: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> fc_out[FC_W-1]);

  // R6
  user_sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!s_bit && !exc_enter && !exc_return) |=> $stable(sr_out));
endmodule

// File: tb/test_priv_sp_ctrl.sv
module test_priv_sp_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid, ins_stop, ins_lpstop, ins_reset, ins_sr_write, ins_usp_move;
  logic        exc_enter, exc_return, sr_wr_en, a7_wr_en, bus_prog, bus_cpu;
  logic [15:0] sr_wr_data;
  logic [31:0] a7_wr_data;
  logic [31:0] sp_out;
  logic        priv_trap;
  logic [2:0]  fc_out;
  logic [15:0] sr_out, sr_saved;

  always #10 clk = ~clk;

  priv_sp_ctrl i_priv_sp_ctrl (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_stop(ins_stop),
    .ins_lpstop(ins_lpstop), .ins_reset(ins_reset), .ins_sr_write(ins_sr_write),
    .ins_usp_move(ins_usp_move), .exc_enter(exc_enter), .exc_return(exc_return),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .a7_wr_en(a7_wr_en),
    .a7_wr_data(a7_wr_data), .bus_prog(bus_prog), .bus_cpu(bus_cpu),
    .sp_out(sp_out), .priv_trap(priv_trap), .fc_out(fc_out),
    .sr_out(sr_out), .sr_saved(sr_saved)
  );

  typedef struct {
    int          sel;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  logic [31:0] act;

  // monitor: compares queued expectations after each rising edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      case (cur.sel)
        0: act = sp_out;
        1: act = {29'd0, fc_out};
        2: act = {31'd0, priv_trap};
        3: act = {16'd0, sr_out};
        default: act = {16'd0, sr_saved};
      endcase
      checks++;
      if (act !== cur.val) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", cur.req, cur.sel, act, cur.val);
      end
    end
  end

  task automatic expect_item(input int sel, input logic [31:0] val, input string req);
    exp_t e;
    e.sel = sel; e.val = val; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    ins_valid = 0; ins_stop = 0; ins_lpstop = 0; ins_reset = 0;
    ins_sr_write = 0; ins_usp_move = 0; exc_enter = 0; exc_return = 0;
    sr_wr_en = 0; sr_wr_data = '0; a7_wr_en = 0; a7_wr_data = '0;
    bus_prog = 1; bus_cpu = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    rst = 0;
    // R1 reset state
    expect_item(3, 32'h2000, "R1");
    expect_item(4, 32'h0, "R1");
    expect_item(0, 32'h0, "R1");
    expect_item(2, 32'h0, "R1");
    expect_item(1, 32'h6, "R2");
    step();

    // supervisor write to register 7 loads supervisor SP
    idle(); a7_wr_en = 1; a7_wr_data = 32'h1000; bus_prog = 0;
    expect_item(0, 32'h1000, "R3");
    expect_item(1, 32'h5, "R2");
    step();

    // user-stack move at supervisor
    idle(); ins_valid = 1; ins_usp_move = 1; a7_wr_en = 1; a7_wr_data = 32'h2000;
    expect_item(0, 32'h2000, "R7");
    expect_item(2, 32'h0, "R7");
    step();

    idle();
    expect_item(0, 32'h1000, "R3");
    step();

    // stop at supervisor: no trap
    idle(); ins_valid = 1; ins_stop = 1;
    expect_item(2, 32'h0, "R5");
    step();

    // drop to user through status write
    idle(); ins_valid = 1; ins_sr_write = 1; sr_wr_en = 1; sr_wr_data = 16'h0000;
    expect_item(2, 32'h0, "R6");
    expect_item(3, 32'h0, "R3");
    expect_item(0, 32'h2000, "R3");
    expect_item(1, 32'h2, "R2");
    step();

    idle(); bus_prog = 0;
    expect_item(1, 32'h1, "R2");
    step();
    idle(); bus_cpu = 1;
    expect_item(1, 32'h7, "R2");
    step();

    // user register-7 write
    idle(); a7_wr_en = 1; a7_wr_data = 32'h2100;
    expect_item(0, 32'h2100, "R4");
    step();

    // privileged instructions at user level
    idle(); ins_valid = 1; ins_stop = 1;
    expect_item(2, 32'h1, "R5");
    step();
    idle();
    expect_item(2, 32'h0, "R5");
    step();
    idle(); ins_valid = 1; ins_lpstop = 1;
    expect_item(2, 32'h1, "R5");
    step();
    idle(); ins_valid = 1; ins_reset = 1;
    expect_item(2, 32'h1, "R5");
    step();

    idle(); ins_valid = 1; ins_sr_write = 1; sr_wr_en = 1; sr_wr_data = 16'h2000;
    expect_item(2, 32'h1, "R6");
    expect_item(3, 32'h0, "R6");
    step();

    idle(); ins_valid = 1; ins_usp_move = 1; a7_wr_en = 1; a7_wr_data = 32'h3000;
    expect_item(2, 32'h1, "R11");
    expect_item(0, 32'h2100, "R11");
    step();

    // exception entry from user level
    idle(); exc_enter = 1; bus_prog = 0;
    expect_item(4, 32'h0, "R8");
    expect_item(3, 32'h2000, "R8");
    expect_item(0, 32'h1000, "R4");
    expect_item(1, 32'h5, "R8");
    step();

    idle(); sr_wr_en = 1; sr_wr_data = 16'h2700;
    expect_item(3, 32'h2700, "R6");
    step();

    idle(); exc_return = 1;
    expect_item(3, 32'h0, "R9");
    expect_item(0, 32'h2100, "R9");
    step();

    // priority cases
    idle(); exc_enter = 1; exc_return = 1;
    expect_item(4, 32'h0, "R10");
    expect_item(3, 32'h2000, "R10");
    step();
    idle(); exc_enter = 1; sr_wr_en = 1; sr_wr_data = 16'h0700;
    expect_item(4, 32'h2000, "R10");
    expect_item(3, 32'h2000, "R10");
    step();

    idle();
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule